// File: doc/BRIEF.md
# Bit-Clock Rate Classifier

The classifier finds out which of the supported bit-clock frequencies is present. It counts bit-clock cycles between successive rising edges of an 8 kHz frame-sync reference and maps that count onto a two-bit rate code. The rest of the device uses the code to set its clocking. The bit clock is also the master clock of the block, and the frame sync is assumed to be generated synchronously to it.

A count is one measurement. A measurement that matches a supported ratio is legal. A rate is accepted only after two consecutive legal measurements fall into the same rate class. After that the valid flag rises and the code is updated. A measurement that matches no supported ratio raises an error flag. So does a missing sync that lets the counter run past its limit. In both cases the code and the valid flag keep their values. The first sync after reset, or after a lost sync, only starts the timing and produces no measurement.

Top module: `clkrate_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs become `rate_code`=0, `rate_valid`=0 and `rate_err`=0 at that edge.
- R2: The cycles counted between two sync rising edges map to rate classes. 1024 gives code 3, 512 gives code 2, 256 gives code 1, and 192 or 193 gives code 0.
- R3: `rate_valid` first rises, with the class as the code, at the sync edge that ends the second consecutive legal measurement of the same class. The first sync after reset is not a measurement.
- R4: While `rate_valid` is high, a single legal measurement of a different class leaves `rate_code` unchanged. A second consecutive one of that class replaces it.
- R5: A measurement of any other count sets `rate_err`. It leaves `rate_code` and `rate_valid` unchanged and clears the pending candidate, so the next legal measurement alone does not change the code.
- R6: `rate_err` clears at the next legal measurement.
- R7: If `OVF_LIMIT` (default 1100) cycles pass after a sync edge with no further edge, `rate_err` is set at that cycle. It is not set a cycle earlier. The candidate is cleared, code and valid are held, and the next sync edge only restarts timing. A period of exactly `OVF_LIMIT` cycles is measured and is illegal.
- R8: The outputs change only at a clock edge where a sync rising edge or an overflow is seen. At every other edge they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, which is also the system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | 8 kHz frame-sync reference, synchronous to `clk` |
| rate_code | output | 2 | Accepted rate class (3 = 1024, 2 = 512, 1 = 256, 0 = 192/193 cycles per frame) |
| rate_valid | output | 1 | High once a rate has been confirmed by two matching frames |
| rate_err | output | 1 | High after an unsupported count or a sync timeout, until the next legal measurement |

## Verification
The assertions assume that `fsync` is synchronous to `clk`, and that each sync pulse is low for at least one cycle before the next rising edge. A period is therefore never shorter than two cycles. The stimulus drives one-cycle pulses at the falling clock edge, with gaps of at least two cycles. The gaps are drawn from the legal counts, repeats of the previous gap, illegal counts up to the limit, and gaps beyond the limit. Directed cases cover the exact overflow cycle, a period equal to the limit, and the mixed 192/193 framing.

// File: rtl/clkrate_pkg.sv
// Package: clkrate_pkg
// Shared widths and the measurement record passed from the decoder to
// the qualifier. Assumes at most three octave rates plus one base rate,
// so a two-bit class is enough.
package clkrate_pkg;
    localparam int CODE_W = 2;

    typedef logic [CODE_W-1:0] rate_code_t;

    // One measurement: strobe marks the sync edge that ends a period
    typedef struct packed {
        logic       strobe;
        logic       legal;
        rate_code_t cls;
    } meas_t;
endpackage

// File: rtl/clkrate_edge.sv
// Module: clkrate_edge
// Finds rising edges of the frame-sync input. Assumes fsync is already
// synchronous to clk, so one register stage is enough for the edge.
module clkrate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic fs_rise
);
    logic fs_q;

    // Keep last sampled level of the sync input
    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= 1'b0;
        else        fs_q <= fsync;
    end

    // Rising edge: high now, low at previous edge
    always_comb fs_rise = fsync & ~fs_q;
endmodule

// File: rtl/clkrate_period.sv
// Module: clkrate_period
// Counts clock cycles since the last sync edge. A sync edge while armed
// emits a measurement strobe carrying the count. A period that reaches
// OVF_LIMIT without an edge raises a one-cycle overflow event and disarms
// the counter, so the next edge only restarts timing.
module clkrate_period #(
    parameter int OVF_LIMIT = 1100,
    parameter int CNT_W     = $clog2(OVF_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_rise,
    output logic [CNT_W-1:0] count,
    output logic             meas_strobe,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(OVF_LIMIT);

    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Overflow: limit reached with no edge in this cycle
    always_comb ovf_evt = armed & ~fs_rise & (cnt == LIMIT_C);

    // Measurement only when a previous edge gave a reference
    always_comb meas_strobe = fs_rise & armed;

    always_comb count = cnt;

    // Cycle counter: restart on edge, drop reference on overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (fs_rise) begin
            cnt   <= CNT_W'(1);
            armed <= 1'b1;
        end else if (ovf_evt) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (armed) begin
            cnt   <= cnt + CNT_W'(1);
        end
    end

    // Counter never runs past the timeout limit
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT_C);

    // After a timeout the following edge must not produce a measurement
    assert_ovf_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> !meas_strobe);
endmodule

// File: rtl/clkrate_decode.sv
// Module: clkrate_decode
// Maps a measured cycle count onto a rate class. The octave rates are
// CPF_FULL >> k for k = 0..NUM_OCT-1 and take class NUM_OCT-k. The two
// base-rate counts take class 0. Any other count is illegal.
module clkrate_decode
    import clkrate_pkg::*;
#(
    parameter int CPF_FULL = 1024,
    parameter int NUM_OCT  = 3,
    parameter int CPF_B_LO = 192,
    parameter int CPF_B_HI = 193,
    parameter int CNT_W    = 11
) (
    input  logic [CNT_W-1:0] count,
    input  logic             strobe,
    output meas_t            meas
);
    logic [NUM_OCT-1:0] oct_hit;
    logic               base_hit;

    // One comparator per octave rate
    for (genvar g = 0; g < NUM_OCT; g++) begin : g_oct
        assign oct_hit[g] = (count == CNT_W'(CPF_FULL >> g));
    end

    // Base rate accepts either frame length
    always_comb base_hit = (count == CNT_W'(CPF_B_LO)) || (count == CNT_W'(CPF_B_HI));

    // Build the measurement record from the comparator hits
    always_comb begin
        meas.strobe = strobe;
        meas.legal  = base_hit;
        meas.cls    = '0;
        for (int i = 0; i < NUM_OCT; i++) begin
            if (oct_hit[i]) begin
                meas.legal = 1'b1;
                meas.cls   = CODE_W'(NUM_OCT - i);
            end
        end
    end
endmodule

// File: rtl/clkrate_qualify.sv
// Module: clkrate_qualify
// Holds the candidate class and the accepted code. A legal measurement
// confirms the code when it matches the candidate. An illegal measurement
// or a timeout flags an error and drops the candidate. Assumes at most one
// of strobe and overflow in a cycle.
module clkrate_qualify
    import clkrate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  meas_t      meas,
    input  logic       ovf_evt,
    output rate_code_t rate_code,
    output logic       rate_valid,
    output logic       rate_err
);
    rate_code_t cand;
    logic       cand_ok;
    logic       good_evt;
    logic       bad_evt;

    // Classify the current event
    always_comb begin
        good_evt = meas.strobe & meas.legal;
        bad_evt  = (meas.strobe & ~meas.legal) | ovf_evt;
    end

    // Candidate, code and flag update on measurement or timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand       <= '0;
            cand_ok    <= 1'b0;
            rate_code  <= '0;
            rate_valid <= 1'b0;
            rate_err   <= 1'b0;
        end else if (good_evt) begin
            rate_err <= 1'b0;
            cand     <= meas.cls;
            cand_ok  <= 1'b1;
            if (cand_ok && (cand == meas.cls)) begin
                rate_code  <= meas.cls;
                rate_valid <= 1'b1;
            end
        end else if (bad_evt) begin
            rate_err <= 1'b1;
            cand_ok  <= 1'b0;
        end
    end

    // Outputs hold when neither a measurement nor a timeout occurs
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas.strobe || ovf_evt) |=> $stable(rate_code) && $stable(rate_valid) && $stable(rate_err));

    // Bad measurement keeps code and valid, and flags an error
    assert_hold_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((meas.strobe && !meas.legal) || ovf_evt) |=> $stable(rate_code) && $stable(rate_valid) && rate_err);

    // Valid can only rise from a legal measurement
    assert_valid_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rate_valid) |-> $past(meas.strobe && meas.legal));

    // Error clears on a legal measurement
    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (meas.strobe && meas.legal) |=> !rate_err);
endmodule

// File: rtl/clkrate_detect.sv
// Module: clkrate_detect
// Top level of the bit-clock rate classifier: edge finder, period
// counter, count decoder and two-frame qualifier. Assumes fsync is
// synchronous to clk and low for at least one cycle between pulses.
module clkrate_detect
    import clkrate_pkg::*;
#(
    parameter int CPF_FULL  = 1024,
    parameter int NUM_OCT   = 3,
    parameter int CPF_B_LO  = 192,
    parameter int CPF_B_HI  = 193,
    parameter int OVF_LIMIT = 1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    output logic [CODE_W-1:0] rate_code,
    output logic              rate_valid,
    output logic              rate_err
);
    localparam int CNT_W = $clog2(OVF_LIMIT + 1);

    logic             fs_rise;
    logic [CNT_W-1:0] count;
    logic             meas_strobe;
    logic             ovf_evt;
    meas_t            meas;

    clkrate_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync   (fsync),
        .fs_rise (fs_rise)
    );

    clkrate_period #(
        .OVF_LIMIT (OVF_LIMIT),
        .CNT_W     (CNT_W)
    ) u_period (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_rise     (fs_rise),
        .count       (count),
        .meas_strobe (meas_strobe),
        .ovf_evt     (ovf_evt)
    );

    clkrate_decode #(
        .CPF_FULL (CPF_FULL),
        .NUM_OCT  (NUM_OCT),
        .CPF_B_LO (CPF_B_LO),
        .CPF_B_HI (CPF_B_HI),
        .CNT_W    (CNT_W)
    ) u_decode (
        .count  (count),
        .strobe (meas_strobe),
        .meas   (meas)
    );

    clkrate_qualify u_qualify (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas       (meas),
        .ovf_evt    (ovf_evt),
        .rate_code  (rate_code),
        .rate_valid (rate_valid),
        .rate_err   (rate_err)
    );

    // Reset state holds one cycle after reset is seen (R1)
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (rate_code == '0) && !rate_valid && !rate_err);
endmodule

// File: tb/clkrate_detect_tb.sv
// Bench for clkrate_detect: directed corner cases plus seeded random
// frame gaps, checked against a period-level reference model.
module clkrate_detect_tb;
    localparam int LIMIT = 1100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [1:0] rate_code;
    logic       rate_valid;
    logic       rate_err;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    int m_code = 0, m_cand = 0;
    bit m_valid = 0, m_err = 0, m_armed = 0, m_cand_ok = 0;
    string m_tag;

    always #2 clk = ~clk;

    clkrate_detect u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .rate_code  (rate_code),
        .rate_valid (rate_valid),
        .rate_err   (rate_err)
    );

    // Expected class from a measured count, -1 when illegal
    function automatic int exp_class(int g);
        case (g)
            1024:     return 3;
            512:      return 2;
            256:      return 1;
            192, 193: return 0;
            default:  return -1;
        endcase
    endfunction

    // Model one sync edge that follows a gap of g cycles
    function automatic void model_pulse(int g);
        int c;
        if (!m_armed) begin
            m_armed = 1; m_tag = "R3";
        end else if (g > LIMIT) begin
            m_err = 1; m_cand_ok = 0; m_tag = "R7";
        end else begin
            c = exp_class(g);
            if (c < 0) begin
                m_err = 1; m_cand_ok = 0; m_tag = "R5";
            end else begin
                m_tag = m_err ? "R6" : "R2";
                m_err = 0;
                if (m_cand_ok && m_cand == c) begin
                    if (m_valid && m_code != c) m_tag = "R4";
                    else if (!m_valid) m_tag = "R3";
                    m_code = c; m_valid = 1;
                end
                m_cand = c; m_cand_ok = 1;
            end
        end
    endfunction

    task automatic check_out(string tag);
        n_checks++;
        if (rate_code !== 2'(m_code) || rate_valid !== m_valid || rate_err !== m_err) begin
            n_fail++;
            $display("FAIL %s: code=%0d valid=%0b err=%0b expected code=%0d valid=%0b err=%0b",
                     tag, rate_code, rate_valid, rate_err, m_code, m_valid, m_err);
        end
    endtask

    // Wait out a gap of g cycles since the last pulse, then send a pulse
    task automatic pulse_after(int g);
        if (g >= 2 && g <= LIMIT) begin
            repeat (g - 2) @(negedge clk);
            check_out("R8");
            @(negedge clk);
        end else if (g > LIMIT) begin
            repeat (g - 1) @(negedge clk);
        end
        fsync = 1'b1;
        @(negedge clk);
        model_pulse(g);
        check_out(m_tag);
        fsync = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fsync = 1'b0;
        repeat (3) @(negedge clk);
        m_code = 0; m_cand = 0; m_valid = 0; m_err = 0; m_armed = 0; m_cand_ok = 0;
        check_out("R1");
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int prev, g, r, reps;
        void'($urandom(32'h5eed_c10c));
        do_reset();
        @(negedge clk);

        // R3: first edge only arms, first measurement does not validate
        pulse_after(1);
        pulse_after(512);
        pulse_after(512);
        // R4: one different frame keeps the code, two change it
        pulse_after(1024);
        pulse_after(1024);
        pulse_after(256);
        pulse_after(256);
        // R2: mixed 192/193 framing is one class
        pulse_after(1024);
        pulse_after(1024);
        pulse_after(192);
        pulse_after(193);
        // R5: illegal count clears the candidate, R6: error clears on a legal one
        pulse_after(256);
        pulse_after(700);
        pulse_after(256);
        pulse_after(256);
        // R7: period exactly at the limit is measured and illegal
        pulse_after(LIMIT);
        pulse_after(512);

        // R7: timeout sets error exactly LIMIT cycles after the edge
        repeat (LIMIT - 1) @(negedge clk);
        check_out("R7");
        @(negedge clk);
        m_err = 1; m_cand_ok = 0; m_armed = 0;
        check_out("R7");
        pulse_after(1);
        pulse_after(512);
        check_out("R7");

        // Random gaps
        prev = 512;
        for (int k = 0; k < 110; k++) begin
            r = int'($urandom_range(0, 9));
            if (r <= 5) begin
                case ($urandom_range(0, 4))
                    0: g = 1024; 1: g = 512; 2: g = 256; 3: g = 192; default: g = 193;
                endcase
            end else if (r == 6) begin
                g = prev;
            end else if (r <= 8) begin
                g = int'($urandom_range(2, LIMIT));
                while (exp_class(g) >= 0) g = int'($urandom_range(2, LIMIT));
            end else begin
                g = int'($urandom_range(LIMIT + 1, 1300));
            end
            reps = int'($urandom_range(1, 2));
            for (int j = 0; j < reps; j++) pulse_after(g);
            prev = g;
        end

        // R1: reset in the middle of operation
        @(negedge clk);
        do_reset();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule